// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading a two-level translation table held in memory. A context register holds the physical address of the first-level table; software reloads it on every context switch through a dedicated write port. When a translation request arrives, the walker reads one word from the first-level table. That word is a pointer to a second-level table. The walker then reads one word from the second-level table. That word is the page entry, and it supplies the physical frame.

The virtual address is split into three fields: bits 31:22 index the first-level table, bits 21:12 index the second-level table, and bits 11:0 are the byte offset inside the page. Every table entry is one 4-byte word. Each read goes out on a simple memory port: a request with a valid/ready handshake, and a response strobe that comes back at least one cycle after the request is accepted.

A walk ends with a single-cycle completion pulse. The pulse carries either a physical address or a page-fault flag. A walk faults when the first-level pointer is invalid or when the page is not usable.

Top module: `pt_walker`

## Requirements
- R1: When a request is accepted, the first memory read goes to the context base captured at acceptance plus 4 times virtual-address bits 31:22.
- R2: If the first-level word has bit 0 (valid) set, the second read goes to that word with bits 11:0 cleared, plus 4 times virtual-address bits 21:12. Bits 11:1 of the pointer word play no other part.
- R3: If the page entry has bit 0 (valid) and bit 1 (resident) both set, the result is reported after exactly two reads. The reported physical address is entry bits 31:12 joined with virtual-address bits 11:0, and the fault flag is 0.
- R4: If the first-level word has bit 0 clear, the walk ends after one read. It reports fault=1 and a physical address of 0.
- R5: If the page entry has bit 0 clear or bit 1 clear, the walk reports fault=1 and a physical address of 0, after two reads.
- R6: `done` is high for exactly one cycle per walk, and `fault` is never high without `done`.
- R7: `req_ready` is high only while the walker is idle. A request presented while a walk is in progress is ignored: it causes no memory read and no result.
- R8: A `base_we` pulse loads `base_wdata` into the context base. A load made during a walk affects only later walks. After reset the base is 0.
- R9: A memory request stays asserted, with a stable address, until `mem_rd_ready` is seen. At most one read is outstanding at a time.
- R10: After reset, `req_ready`=1, `done`=0 and `mem_rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Context-switch load strobe for the table base |
| base_wdata | input | 32 | New physical base of the first-level table |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_va | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Page fault, valid with done |
| pa | output | 32 | Physical address, valid with done and no fault |

## Verification
The bench builds the walker with its default 32-bit layout: 10 plus 10 index bits, a 12-bit offset and 4-byte entries. The memory is modelled as a function of the address, so every first-level index and every second-level index can be swept without storing any table. The sweeps use read latencies from one to four cycles, and ready stalls are turned on and off. Two context bases with different validity patterns are used, along with a base reload during a walk and junk requests held while the walker is busy. Together these exercise both fault depths, pointer and page-entry masking, and the handshake hold rules.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_READ_L0,
      WS_READ_L1,
      WS_DONE,
      WS_FAULT
   } walk_st_e;

   localparam int unsigned ENT_VALID_BIT    = 0;
   localparam int unsigned ENT_RESIDENT_BIT = 1;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
   parameter int unsigned PA_W     = 32,
   parameter logic [PA_W-1:0] RST_BASE = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PA_W-1:0] wdata,
   output logic [PA_W-1:0] base
);

   logic [PA_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  base_q <= RST_BASE;
      else if (we) base_q <= wdata;
   end

   assign base = base_q;

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned PA_W        = 32,
   parameter int unsigned IDX_W       = 10,
   parameter int unsigned ENTRY_BYTES = 4,
   parameter int unsigned ALIGN_W     = 0
) (
   input  logic [PA_W-1:0]  tbl_base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  ent_addr
);

   localparam logic [PA_W-1:0] LOW_MASK  = (PA_W'(1) << ALIGN_W) - PA_W'(1);
   localparam bit              IS_POW2   = (ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0;
   localparam int unsigned     SHIFT     = $clog2(ENTRY_BYTES);

   logic [PA_W-1:0] aligned;
   logic [PA_W-1:0] offs;

   if (IDX_W + SHIFT > PA_W) begin : g_bad_width
      $error("ptw_addr_gen: index span exceeds address width");
   end

   assign aligned = tbl_base & ~LOW_MASK;

   if (IS_POW2) begin : g_shift
      assign offs = PA_W'(idx) << SHIFT;
   end else begin : g_mul
      assign offs = PA_W'(idx) * PA_W'(ENTRY_BYTES);
   end

   assign ent_addr = aligned + offs;

endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
   import ptw_pkg::*;
#(
   parameter int unsigned PA_W     = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned OFF_W    = 12,
   parameter int unsigned L1_IDX_W = 10,
   localparam int unsigned LOW_W   = L1_IDX_W + OFF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [LOW_W-1:0]    req_va_low,
   input  logic [PA_W-1:0]     l0_addr,
   input  logic [PA_W-1:0]     l1_addr,
   output logic [L1_IDX_W-1:0] l1_idx,
   output logic                rd_valid,
   input  logic                rd_ready,
   output logic [PA_W-1:0]     rd_addr,
   input  logic                rsp_valid,
   input  logic [DATA_W-1:0]   rsp_data,
   output logic                done,
   output logic                fault,
   output logic [PA_W-1:0]     pa
);

   localparam logic [PA_W-1:0] FRAME_MASK = ~((PA_W'(1) << OFF_W) - PA_W'(1));

   walk_st_e         st_q;
   logic [LOW_W-1:0] va_q;
   logic [PA_W-1:0]  addr_q;
   logic [PA_W-1:0]  pa_q;
   logic             issued_q;
   logic             rsp_take;
   logic             ent_ok;
   logic             pte_ok;

   if (PA_W > DATA_W) begin : g_bad_data
      $error("ptw_walk_fsm: entry word narrower than physical address");
   end

   assign rsp_take = issued_q && rsp_valid;
   assign ent_ok   = rsp_data[ENT_VALID_BIT];
   assign pte_ok   = rsp_data[ENT_VALID_BIT] && rsp_data[ENT_RESIDENT_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= WS_IDLE;
         va_q     <= '0;
         addr_q   <= '0;
         pa_q     <= '0;
         issued_q <= 1'b0;
      end else begin
         case (st_q)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q     <= req_va_low;
                  addr_q   <= l0_addr;
                  issued_q <= 1'b0;
                  st_q     <= WS_READ_L0;
               end
            end
            WS_READ_L0: begin
               if (rd_valid && rd_ready) issued_q <= 1'b1;
               if (rsp_take) begin
                  if (ent_ok) begin
                     addr_q   <= l1_addr;
                     issued_q <= 1'b0;
                     st_q     <= WS_READ_L1;
                  end else begin
                     st_q <= WS_FAULT;
                  end
               end
            end
            WS_READ_L1: begin
               if (rd_valid && rd_ready) issued_q <= 1'b1;
               if (rsp_take) begin
                  if (pte_ok) begin
                     pa_q <= (rsp_data[PA_W-1:0] & FRAME_MASK) | PA_W'(va_q[OFF_W-1:0]);
                     st_q <= WS_DONE;
                  end else begin
                     st_q <= WS_FAULT;
                  end
               end
            end
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == WS_IDLE);
   assign rd_valid  = ((st_q == WS_READ_L0) || (st_q == WS_READ_L1)) && !issued_q;
   assign rd_addr   = addr_q;
   assign l1_idx    = va_q[LOW_W-1:OFF_W];
   assign done      = (st_q == WS_DONE) || (st_q == WS_FAULT);
   assign fault     = (st_q == WS_FAULT);
   assign pa        = (st_q == WS_DONE) ? pa_q : '0;

   assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fault_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);

   assert_idle_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !rd_valid);

   assert_fault_pa_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (pa == '0));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned PA_W     = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned L0_IDX_W = 10,
   parameter int unsigned L1_IDX_W = 10,
   parameter int unsigned OFF_W    = 12,
   parameter logic [PA_W-1:0] RST_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [PA_W-1:0]   base_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              done,
   output logic              fault,
   output logic [PA_W-1:0]   pa
);

   localparam int unsigned ENTRY_BYTES = DATA_W / 8;
   localparam int unsigned LOW_W       = L1_IDX_W + OFF_W;

   if (L0_IDX_W + L1_IDX_W + OFF_W != VA_W) begin : g_bad_split
      $error("pt_walker: index and offset fields must cover the virtual address");
   end
   if (DATA_W % 8 != 0) begin : g_bad_word
      $error("pt_walker: entry word must be whole bytes");
   end
   if (L1_IDX_W + $clog2(ENTRY_BYTES) > OFF_W) begin : g_bad_table
      $error("pt_walker: second-level table must fit in one page");
   end

   logic [PA_W-1:0]     base;
   logic [PA_W-1:0]     l0_addr;
   logic [PA_W-1:0]     l1_addr;
   logic [L1_IDX_W-1:0] l1_idx;

   ptw_base_reg #(.PA_W(PA_W), .RST_BASE(RST_BASE)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (base_we),
      .wdata (base_wdata),
      .base  (base)
   );

   ptw_addr_gen #(.PA_W(PA_W), .IDX_W(L0_IDX_W), .ENTRY_BYTES(ENTRY_BYTES), .ALIGN_W(0)) u_l0_addr (
      .tbl_base (base),
      .idx      (req_va[VA_W-1 -: L0_IDX_W]),
      .ent_addr (l0_addr)
   );

   ptw_addr_gen #(.PA_W(PA_W), .IDX_W(L1_IDX_W), .ENTRY_BYTES(ENTRY_BYTES), .ALIGN_W(OFF_W)) u_l1_addr (
      .tbl_base (mem_rsp_data[PA_W-1:0]),
      .idx      (l1_idx),
      .ent_addr (l1_addr)
   );

   ptw_walk_fsm #(.PA_W(PA_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .L1_IDX_W(L1_IDX_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_va_low (req_va[LOW_W-1:0]),
      .l0_addr    (l0_addr),
      .l1_addr    (l1_addr),
      .l1_idx     (l1_idx),
      .rd_valid   (mem_rd_valid),
      .rd_ready   (mem_rd_ready),
      .rd_addr    (mem_rd_addr),
      .rsp_valid  (mem_rsp_valid),
      .rsp_data   (mem_rsp_data),
      .done       (done),
      .fault      (fault),
      .pa         (pa)
   );

endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_we = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b1;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done;
   logic        fault;
   logic [31:0] pa;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   int lat_cfg = 1;
   bit stall_en = 0;
   int cyc = 0;
   int rd_cnt = 0;
   int pend = 0;
   logic [31:0] pend_addr = '0;
   logic [31:0] log_addr [2];

   always #5 clk = ~clk;

   pt_walker u0 (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .fault(fault), .pa(pa)
   );

   // memory contents as a function of the byte address
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] pg;
      int i;
      logic v;
      logic r;
      pg = a >> 12;
      i  = int'(a[11:2]);
      if (pg == 32'h0) begin
         v = (i % 4) != 3;
         return (32'(1 + i % 3) << 12) | ((32'(i) << 2) & 32'hFFC) | 32'(v);
      end else if (pg == 32'h100) begin
         v = (i % 2) == 0;
         return (32'(8 + i % 5) << 12) | ((32'(i * 3) << 2) & 32'hFFC) | 32'(v);
      end else if ((pg >= 1 && pg <= 3) || (pg >= 8 && pg <= 12)) begin
         v = (i % 5) != 4;
         r = (i % 7) != 6;
         return ((32'(int'(pg) * 1031 + i * 7 + 5) & 32'hFFFFF) << 12)
              | ((32'(i) << 2) & 32'hFFC) | (32'(r) << 1) | 32'(v);
      end
      return 32'hDEAD_BEE0;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: decisions made at the falling edge for the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         mem_rsp_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = mem_word(pend_addr);
            end
         end
         mem_rd_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
         if (mem_rd_valid && mem_rd_ready && rst_n) begin
            pend      = lat_cfg;
            pend_addr = mem_rd_addr;
            if (rd_cnt < 2) log_addr[rd_cnt] = mem_rd_addr;
            rd_cnt++;
         end
      end
   end

   task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit junk,
                       input bit reload, input logic [31:0] new_base);
      logic [31:0] a0, e0, a1, e1, exp_pa;
      bit exp_f;
      int exp_n;
      int n;
      a0 = base + 32'(va[31:22]) * 4;
      e0 = mem_word(a0);
      a1 = '0;
      exp_pa = '0;
      if (!e0[0]) begin
         exp_f = 1; exp_n = 1;
      end else begin
         a1 = (e0 & 32'hFFFF_F000) + 32'(va[21:12]) * 4;
         e1 = mem_word(a1);
         exp_n = 2;
         exp_f = !(e1[0] && e1[1]);
         if (!exp_f) exp_pa = (e1 & 32'hFFFF_F000) | 32'(va[11:0]);
      end
      @(negedge clk);
      check(req_ready === 1'b1, "R7 ready when idle", 32'(req_ready), 1);
      rd_cnt = 0;
      req_valid = 1'b1;
      req_va = va;
      @(negedge clk);
      check(req_ready === 1'b0, "R7 not ready while busy", 32'(req_ready), 0);
      if (junk) req_va = ~va;
      else req_valid = 1'b0;
      if (reload) begin
         base_we = 1'b1; base_wdata = new_base;
         @(negedge clk);
         base_we = 1'b0;
      end
      n = 0;
      while (done !== 1'b1 && n < 300) begin
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      check(done === 1'b1, "R6 done seen", 32'(done), 1);
      check(fault === exp_f, exp_f ? (exp_n == 1 ? "R4 first-level fault" : "R5 page fault")
                                   : "R3 no fault", 32'(fault), 32'(exp_f));
      check(pa === exp_pa, exp_f ? "R5 pa zero on fault" : "R3 physical address", pa, exp_pa);
      check(rd_cnt == exp_n, exp_n == 1 ? "R4 one read" : "R3 two reads", 32'(rd_cnt), 32'(exp_n));
      check(log_addr[0] === a0, "R1 first-level address", log_addr[0], a0);
      if (exp_n == 2)
         check(log_addr[1] === a1, "R2 second-level address", log_addr[1], a1);
      @(negedge clk);
      check(done === 1'b0 && fault === 1'b0, "R6 single-cycle pulse", 32'({done, fault}), 0);
      repeat (2) @(negedge clk);
      check(rd_cnt == exp_n, junk ? "R7 busy request ignored" : "R9 no stray read",
            32'(rd_cnt), 32'(exp_n));
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] cur_base;
      repeat (3) @(negedge clk);
      check(req_ready === 1'b1, "R10 reset ready", 32'(req_ready), 1);
      check(done === 1'b0, "R10 reset done", 32'(done), 0);
      check(mem_rd_valid === 1'b0, "R10 reset no read", 32'(mem_rd_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cur_base = 32'h0;   // R8 reset base is 0
      // sweep every first-level index
      for (int i = 0; i < 1024; i++) begin
         lat_cfg  = 1 + (i % 4);
         stall_en = (i / 8) % 2 == 1;
         walk({10'(i), 10'((i * 37 + 11) % 1024), 12'((i * 613) % 4096)}, cur_base,
              (i % 7) == 3, 1'b0, '0);
      end
      // sweep every second-level index under a valid pointer
      for (int j = 0; j < 1024; j++) begin
         lat_cfg  = 1 + ((j / 3) % 4);
         stall_en = (j % 2) == 0;
         walk({10'd1, 10'(j), 12'((j * 2741) % 4096)}, cur_base, (j % 11) == 5, 1'b0, '0);
      end
      // R8 reload mid-walk: current walk uses old base
      lat_cfg = 3; stall_en = 1;
      walk({10'd4, 10'd9, 12'h123}, cur_base, 1'b0, 1'b1, 32'h0010_0000);
      cur_base = 32'h0010_0000;
      // R8 walks under the new context base
      for (int i = 0; i < 64; i++) begin
         lat_cfg  = 1 + (i % 3);
         stall_en = (i % 4) == 1;
         walk({10'(i * 16 + 1), 10'((i * 97) % 1024), 12'(i * 63)}, cur_base, 1'b0, 1'b0, '0);
      end
      // R8 switch back between walks
      @(negedge clk);
      base_we = 1'b1; base_wdata = 32'h0;
      @(negedge clk);
      base_we = 1'b0;
      cur_base = 32'h0;
      for (int i = 0; i < 16; i++) begin
         lat_cfg = 2;
         walk({10'(i), 10'(i * 5), 12'hABC}, cur_base, 1'b0, 1'b0, '0);
      end
      summary();
   end

endmodule